// File: doc/BRIEF.md
# Console CPU Address Router with Sprite Block Copy

This block sits on the 16-bit address bus of an 8-bit CPU and steers each access to one target: a 2 KB work RAM held inside the block, a bank of eight video-unit registers, the audio-unit registers, two controller inputs with a shared strobe, or the cartridge space. Each target outside the block is a plain request/response port. Every access takes one CPU cycle. Read data comes back in the same cycle, through a combinational path from the selected target.

A write to the block-copy trigger address starts a copy engine, which holds the CPU stalled while it runs. The engine copies 256 bytes from the 256-byte page named by the written value into the video unit's sprite-data register. It spends one cycle reading each byte and one cycle writing it. The engine drives the same internal bus that the CPU uses, so its reads pass through the same address decode and can come from RAM, the cartridge or any other readable target.

The engine has three states. In `DMA_IDLE` the CPU owns the bus; a trigger write moves the engine to `DMA_FETCH`. In `DMA_FETCH` the engine reads source byte i and latches it, then always moves to `DMA_STORE`. In `DMA_STORE` the engine writes the latched byte to the sprite-data register. From there it returns to `DMA_FETCH` if bytes remain, or to `DMA_IDLE` after byte 255.

Top module: `sysbus_router`

## Requirements
- R1: Addresses 0x0000–0x1FFF access the internal RAM at index address mod 0x800. A read returns the stored byte in the same cycle. A RAM access raises none of vid_req, aud_req or cart_req.
- R2: Addresses 0x2000–0x3FFF raise vid_req with vid_reg equal to address bits [2:0]. A read returns vid_rdata.
- R3: Addresses 0x4000–0x4013 and 0x4015, read or written, raise aud_req with aud_addr equal to address bits [4:0]. A write to 0x4017 also goes to the audio port. A read returns aud_rdata.
- R4: A write to 0x4016 loads pad_strobe with data bit 0, and pad_strobe keeps that value until the next such write. A read of 0x4016 returns pad_in0 and pulses pad_rd0. A read of 0x4017 returns pad_in1 and pulses pad_rd1.
- R5: Addresses 0x4018–0xFFFF raise cart_req and pass the full address to cart_addr. A read returns cart_rdata.
- R6: A read of 0x4014 returns 0x00 and raises no external request.
- R7: A write of value v to 0x4014 copies 256 bytes. The byte from address v*0x100+i, for i from 0 to 255 in ascending order, is written to video register 4. Each byte takes one read cycle followed by one write cycle.
- R8: cpu_stall goes high in the cycle after the trigger write and stays high for exactly 512 cycles.
- R9: While cpu_stall is high, CPU accesses have no effect. A RAM write is dropped, and a second trigger write neither restarts nor extends the copy.
- R10: After reset, cpu_stall and pad_strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access in this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, same cycle |
| cpu_stall | output | 1 | Copy engine owns the bus |
| vid_req | output | 1 | Video register access |
| vid_we | output | 1 | Video write |
| vid_reg | output | 3 | Video register index |
| vid_wdata | output | 8 | Video write data |
| vid_rdata | input | 8 | Video read data |
| aud_req | output | 1 | Audio register access |
| aud_we | output | 1 | Audio write |
| aud_addr | output | 5 | Audio register index |
| aud_wdata | output | 8 | Audio write data |
| aud_rdata | input | 8 | Audio read data |
| pad_strobe | output | 1 | Controller latch strobe |
| pad_rd0 | output | 1 | Read pulse, controller 0 |
| pad_rd1 | output | 1 | Read pulse, controller 1 |
| pad_in0 | input | 8 | Controller 0 data |
| pad_in1 | input | 8 | Controller 1 data |
| cart_req | output | 1 | Cartridge access |
| cart_we | output | 1 | Cartridge write |
| cart_addr | output | 16 | Cartridge address |
| cart_wdata | output | 8 | Cartridge write data |
| cart_rdata | input | 8 | Cartridge read data |

## Verification
The bench reads every one of the 65,536 addresses and compares the data and the raised request against an expected target computed from the address. This catches an off-by-one range edge at 0x1FFF/0x2000, 0x4013/0x4014/0x4015 or 0x4017/0x4018, and a RAM mirror with the wrong modulus, which would return bytes from the wrong copy. The direction-dependent addresses 0x4014, 0x4016 and 0x4017 are also written. A decoder that ignored the access direction would send controller reads to the audio port, or let a read start a copy. The bench runs two copies, one sourced from RAM and one from the cartridge, and checks every beat. It injects a RAM write and a second trigger in the middle of a copy. A wrong per-byte order, a beat count off by one, or a bus that still accepted CPU accesses while stalled would show up as a mismatched beat, a wrong stall length, or corrupted RAM.

// File: rtl/sysbus_pkg.sv
package sysbus_pkg;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_RAM,
        TGT_VID,
        TGT_AUD,
        TGT_PAD0,
        TGT_PAD1,
        TGT_STROBE,
        TGT_DMA,
        TGT_CART
    } tgt_e;

    typedef enum logic [1:0] {
        DMA_IDLE,
        DMA_FETCH,
        DMA_STORE
    } dma_state_e;

    localparam logic [15:0] VID_BASE   = 16'h2000;
    localparam logic [15:0] IO_BASE    = 16'h4000;
    localparam logic [15:0] AUD_LAST   = 16'h4013;
    localparam logic [15:0] DMA_TRIG   = 16'h4014;
    localparam logic [15:0] AUD_CTRL   = 16'h4015;
    localparam logic [15:0] PAD0_ADDR  = 16'h4016;
    localparam logic [15:0] PAD1_ADDR  = 16'h4017;
    localparam logic [15:0] CART_BASE  = 16'h4018;

    function automatic tgt_e map_addr(input logic [15:0] a, input logic we);
        tgt_e t;
        if (a < VID_BASE)                      t = TGT_RAM;
        else if (a < IO_BASE)                  t = TGT_VID;
        else if (a <= AUD_LAST || a == AUD_CTRL) t = TGT_AUD;
        else if (a == DMA_TRIG)                t = we ? TGT_DMA : TGT_NONE;
        else if (a == PAD0_ADDR)               t = we ? TGT_STROBE : TGT_PAD0;
        else if (a == PAD1_ADDR)               t = we ? TGT_AUD : TGT_PAD1;
        else                                   t = TGT_CART;
        return t;
    endfunction

endpackage

// File: rtl/sysbus_decode.sv
module sysbus_decode
    import sysbus_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output tgt_e              tgt
);
    always_comb begin
        tgt = map_addr(addr, we);
    end
endmodule

// File: rtl/sysbus_ram.sv
module sysbus_ram #(
    parameter int DEPTH  = 2048,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/sysbus_dma.sv
module sysbus_dma
    import sysbus_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int XFER     = 256,
    parameter int PORT_REG = 4,
    localparam int IDX_W   = $clog2(XFER),
    localparam int PAGE_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] page,
    input  logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);
    dma_state_e        state, state_nx;
    logic [PAGE_W-1:0] page_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] byte_q;
    logic              last;

    assign last = (idx_q == IDX_W'(XFER - 1));

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= DMA_IDLE;
            page_q <= '0;
            idx_q  <= '0;
            byte_q <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                DMA_IDLE: if (start) begin
                    page_q <= page;
                    idx_q  <= '0;
                end
                DMA_FETCH: byte_q <= rd_data;
                DMA_STORE: idx_q  <= idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DMA_IDLE:  if (start) state_nx = DMA_FETCH;
            DMA_FETCH: state_nx = DMA_STORE;
            DMA_STORE: state_nx = last ? DMA_IDLE : DMA_FETCH;
            default:   state_nx = DMA_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = {page_q, idx_q};
        bus_wdata = byte_q;
        unique case (state)
            DMA_IDLE: ;
            DMA_FETCH: busy = 1'b1;
            DMA_STORE: begin
                busy     = 1'b1;
                bus_we   = 1'b1;
                bus_addr = VID_BASE + ADDR_W'(PORT_REG);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sysbus_router.sv
module sysbus_router
    import sysbus_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int RAM_BYTES = 2048,
    parameter int VID_SEL_W = 3,
    parameter int AUD_SEL_W = 5,
    parameter int DMA_LEN   = 256,
    parameter int DMA_REG   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    output logic [DATA_W-1:0]    cpu_rdata,
    output logic                 cpu_stall,
    output logic                 vid_req,
    output logic                 vid_we,
    output logic [VID_SEL_W-1:0] vid_reg,
    output logic [DATA_W-1:0]    vid_wdata,
    input  logic [DATA_W-1:0]    vid_rdata,
    output logic                 aud_req,
    output logic                 aud_we,
    output logic [AUD_SEL_W-1:0] aud_addr,
    output logic [DATA_W-1:0]    aud_wdata,
    input  logic [DATA_W-1:0]    aud_rdata,
    output logic                 pad_strobe,
    output logic                 pad_rd0,
    output logic                 pad_rd1,
    input  logic [DATA_W-1:0]    pad_in0,
    input  logic [DATA_W-1:0]    pad_in1,
    output logic                 cart_req,
    output logic                 cart_we,
    output logic [ADDR_W-1:0]    cart_addr,
    output logic [DATA_W-1:0]    cart_wdata,
    input  logic [DATA_W-1:0]    cart_rdata
);
    localparam int RAM_IDX_W = $clog2(RAM_BYTES);
    localparam int PAGE_W    = ADDR_W - $clog2(DMA_LEN);

    logic              dma_busy, dma_we, dma_start;
    logic [ADDR_W-1:0] dma_addr;
    logic [DATA_W-1:0] dma_wdata, ram_rdata;
    logic              bus_req, bus_we;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata, bus_rdata;
    tgt_e              tgt;

    // bus owner: copy engine while busy, CPU otherwise
    always_comb begin
        if (dma_busy) begin
            bus_req   = 1'b1;
            bus_we    = dma_we;
            bus_addr  = dma_addr;
            bus_wdata = dma_wdata;
        end else begin
            bus_req   = cpu_req;
            bus_we    = cpu_we;
            bus_addr  = cpu_addr;
            bus_wdata = cpu_wdata;
        end
    end

    sysbus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .tgt  (tgt)
    );

    sysbus_ram #(.DEPTH(RAM_BYTES), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .wr_en (bus_req && bus_we && tgt == TGT_RAM),
        .idx   (bus_addr[RAM_IDX_W-1:0]),
        .wdata (bus_wdata),
        .rdata (ram_rdata)
    );

    assign dma_start = !dma_busy && cpu_req && cpu_we && tgt == TGT_DMA;

    sysbus_dma #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .XFER(DMA_LEN), .PORT_REG(DMA_REG)
    ) u_dma (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (dma_start),
        .page      (cpu_wdata[PAGE_W-1:0]),
        .rd_data   (bus_rdata),
        .busy      (dma_busy),
        .bus_we    (dma_we),
        .bus_addr  (dma_addr),
        .bus_wdata (dma_wdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            pad_strobe <= 1'b0;
        else if (bus_req && bus_we && tgt == TGT_STROBE)
            pad_strobe <= bus_wdata[0];
    end

    always_comb begin
        unique case (tgt)
            TGT_RAM:  bus_rdata = ram_rdata;
            TGT_VID:  bus_rdata = vid_rdata;
            TGT_AUD:  bus_rdata = aud_rdata;
            TGT_PAD0: bus_rdata = pad_in0;
            TGT_PAD1: bus_rdata = pad_in1;
            TGT_CART: bus_rdata = cart_rdata;
            default:  bus_rdata = '0;
        endcase
    end

    assign cpu_rdata  = bus_rdata;
    assign cpu_stall  = dma_busy;
    assign vid_req    = bus_req && tgt == TGT_VID;
    assign vid_we     = bus_we;
    assign vid_reg    = bus_addr[VID_SEL_W-1:0];
    assign vid_wdata  = bus_wdata;
    assign aud_req    = bus_req && tgt == TGT_AUD;
    assign aud_we     = bus_we;
    assign aud_addr   = bus_addr[AUD_SEL_W-1:0];
    assign aud_wdata  = bus_wdata;
    assign pad_rd0    = bus_req && !bus_we && tgt == TGT_PAD0;
    assign pad_rd1    = bus_req && !bus_we && tgt == TGT_PAD1;
    assign cart_req   = bus_req && tgt == TGT_CART;
    assign cart_we    = bus_we;
    assign cart_addr  = bus_addr;
    assign cart_wdata = bus_wdata;
endmodule

// File: rtl/sysbus_router_chk.sv
module sysbus_router_chk #(
    parameter int XFER = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_stall,
    input logic        vid_req,
    input logic        vid_we,
    input logic [2:0]  vid_reg,
    input logic        aud_req,
    input logic        pad_strobe,
    input logic        cart_req,
    input logic [15:0] cart_addr
);
    localparam int CNT_W = $clog2(2 * XFER) + 1;
    logic [CNT_W-1:0] stall_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)         stall_cnt <= '0;
        else if (cpu_stall) stall_cnt <= stall_cnt + 1'b1;
        else                stall_cnt <= '0;
    end

    a_r1_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vid_req, aud_req, cart_req}));

    a_r5_cart_range: assert property (@(posedge clk) disable iff (!rst_n)
        cart_req |-> cart_addr >= 16'h4018);

    a_r7_store_target: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && vid_req && vid_we) |-> vid_reg == 3'd4);

    a_r8_stall_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_stall) |-> stall_cnt == CNT_W'(2 * XFER));

    a_r8_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> stall_cnt < CNT_W'(2 * XFER));

    a_r4_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_req && cpu_we && cpu_addr == 16'h4016 && !cpu_stall) |=> $stable(pad_strobe));
endmodule

bind sysbus_router sysbus_router_chk #(.XFER(DMA_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_stall  (cpu_stall),
    .vid_req    (vid_req),
    .vid_we     (vid_we),
    .vid_reg    (vid_reg),
    .aud_req    (aud_req),
    .pad_strobe (pad_strobe),
    .cart_req   (cart_req),
    .cart_addr  (cart_addr)
);

// File: tb/sysbus_router_test.sv
module sysbus_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_stall;
    logic        vid_req, vid_we, aud_req, aud_we;
    logic [2:0]  vid_reg;
    logic [4:0]  aud_addr;
    logic [7:0]  vid_wdata, aud_wdata, cart_wdata;
    logic [7:0]  vid_rdata, aud_rdata, cart_rdata;
    logic        pad_strobe, pad_rd0, pad_rd1, cart_req, cart_we;
    logic [15:0] cart_addr;
    logic [7:0]  pad_in0 = 8'h41, pad_in1 = 8'h82;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign vid_rdata  = {5'b10100, vid_reg};
    assign aud_rdata  = {3'b011, aud_addr};
    assign cart_rdata = cart_addr[15:8] ^ cart_addr[7:0];

    sysbus_router uut (.*);

    function automatic logic [7:0] ram_pat(input int a);
        return 8'((a % 2048) * 3 + 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic w, input logic [15:0] a, input logic [7:0] d);
        cpu_req = r; cpu_we = w; cpu_addr = a; cpu_wdata = d;
    endtask

    // runs a copy from page pg; source data function chosen by from_ram
    task automatic run_copy(input logic [7:0] pg, input bit from_ram, input bit inject);
        int vcount = 0;
        @(negedge clk);
        drive(1, 1, 16'h4014, pg);
        @(negedge clk);
        drive(0, 0, 16'h0000, 8'h00);
        for (int k = 0; k < 512; k++) begin
            if (inject && k == 3) drive(1, 1, 16'h0300, 8'hEE);
            if (inject && k == 5) drive(1, 1, 16'h4014, 8'h80);
            #1;
            if (!cpu_stall) begin
                chk("R8 stall high", cpu_stall, 1);
            end else if (k % 2 == 1) begin
                int i = k / 2;
                logic [15:0] src = {pg, 8'(i)};
                logic [7:0]  exp = from_ram ? ram_pat(src) : (pg ^ 8'(i));
                vcount++;
                if (!(vid_req && vid_we && vid_reg == 3'd4) || vid_wdata != exp) begin
                    chk("R7 store beat", {vid_req, vid_we, vid_reg, vid_wdata},
                        {1'b1, 1'b1, 3'd4, exp});
                end
            end else if (!from_ram) begin
                if (!(cart_req && !cart_we && cart_addr == {pg, 8'(k / 2)}))
                    chk("R7 fetch beat", {cart_req, cart_we, cart_addr},
                        {1'b1, 1'b0, pg, 8'(k / 2)});
            end
            @(negedge clk);
            drive(0, 0, 16'h0000, 8'h00);
        end
        #1;
        chk("R7 beat count", vcount, 256);
        chk("R8 stall ends after 512", cpu_stall, 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R10 stall reset", cpu_stall, 0);
        chk("R10 strobe reset", pad_strobe, 0);

        // preload RAM through the CPU
        for (int a = 0; a < 2048; a++) begin
            @(negedge clk);
            drive(1, 1, 16'(a), ram_pat(a));
        end

        // full read sweep of the address space
        for (int a = 0; a < 65536; a++) begin
            logic [7:0] exp;
            logic [2:0] req_exp;
            string tag;
            @(negedge clk);
            drive(1, 0, 16'(a), 8'h00);
            #1;
            if (a < 16'h2000) begin
                exp = ram_pat(a); req_exp = 3'b000; tag = "R1 RAM mirror";
            end else if (a < 16'h4000) begin
                exp = {5'b10100, 3'(a)}; req_exp = 3'b100; tag = "R2 video mirror";
            end else if (a <= 16'h4013 || a == 16'h4015) begin
                exp = {3'b011, 5'(a)}; req_exp = 3'b010; tag = "R3 audio read";
            end else if (a == 16'h4014) begin
                exp = 8'h00; req_exp = 3'b000; tag = "R6 unmapped read";
            end else if (a == 16'h4016) begin
                exp = 8'h41; req_exp = 3'b000; tag = "R4 pad0 read";
            end else if (a == 16'h4017) begin
                exp = 8'h82; req_exp = 3'b000; tag = "R4 pad1 read";
            end else begin
                exp = 8'(a >> 8) ^ 8'(a); req_exp = 3'b001; tag = "R5 cart read";
            end
            if (cpu_rdata != exp || {vid_req, aud_req, cart_req} != req_exp
                || pad_rd0 != (a == 16'h4016) || pad_rd1 != (a == 16'h4017)
                || (vid_req && vid_reg != 3'(a)) || (aud_req && aud_addr != 5'(a))
                || (cart_req && cart_addr != 16'(a)))
                chk(tag, {cpu_rdata, vid_req, aud_req, cart_req, pad_rd0, pad_rd1},
                    {exp, req_exp, a == 16'h4016, a == 16'h4017});
            else
                checks++;
        end

        // write sweep of the I/O window (trigger address excluded)
        for (int a = 16'h4000; a < 16'h4020; a++) begin
            if (a == 16'h4014) continue;
            @(negedge clk);
            drive(1, 1, 16'(a), 8'h5B);
            #1;
            if (a <= 16'h4013 || a == 16'h4015 || a == 16'h4017)
                chk("R3 audio write", {aud_req, aud_we, aud_addr, cart_req}, {2'b11, 5'(a), 1'b0});
            else if (a == 16'h4016)
                chk("R4 strobe write no port", {aud_req, cart_req, pad_rd0}, 3'b000);
            else
                chk("R5 cart write", {cart_req, cart_we, cart_addr}, {2'b11, 16'(a)});
        end
        @(negedge clk); drive(0, 0, 0, 0); #1;
        chk("R4 strobe loads bit0", pad_strobe, 1);
        drive(1, 1, 16'h4016, 8'hFE);
        @(negedge clk); drive(1, 0, 16'h0010, 0); #1;
        chk("R4 strobe cleared", pad_strobe, 0);
        repeat (4) @(negedge clk);
        #1;
        chk("R4 strobe holds", pad_strobe, 0);

        // copy from RAM page 3 with disturbances, then from cartridge page 0x91
        chk("R6 read of trigger starts nothing", cpu_stall, 0);
        run_copy(8'h03, 1, 1);
        @(negedge clk); drive(1, 0, 16'h0300, 0); #1;
        chk("R9 RAM write dropped while stalled", cpu_rdata, ram_pat(16'h0300));
        @(negedge clk); drive(0, 0, 0, 0); #1;
        chk("R9 no restart after copy", cpu_stall, 0);
        run_copy(8'h91, 0, 0);
        @(negedge clk); drive(1, 0, 16'h0B05, 0); #1;
        chk("R1 RAM intact after copies", cpu_rdata, ram_pat(16'h0305));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule